// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a programmable countdown timer clocked by the bus clock and attached to a small register interface. Software loads a start value, picks a clock divisor through a 4-bit divide setting, and programs a timer entry that holds an interrupt vector, a mask bit and a one-shot or periodic selector. After a number of bus cycles equal to the start value times the divisor, the count reaches its end. If the timer entry is unmasked at that point, the block raises a one-cycle interrupt request that carries the programmed vector.

The same register set holds five further local interrupt entries and a unit-control register with a software enable bit. While the unit is software-disabled, every entry is kept masked. Clearing the enable bit masks all six entries at once and cancels a timer interrupt that would otherwise fire in that cycle. Register writes take effect at the next clock edge. Reads are combinational and are selected by a separate read select.

Top module: `local_irq_timer`

## Requirements
- R1: After reset all six local entries (selects 0 to 5) read 0x00010000 (mask bit 16 set), the divide setting (select 9), start value (select 7) and current count (select 8) read zero, and the unit-control register (select 6) reads 0x0FF, which means disabled.
- R2: The divide setting uses bits 3, 1 and 0 as a 3-bit code {b3,b1,b0}. With n = (code + 1) mod 8, the divisor is 2^n. Code 0b1011 gives divide-by-1 and 0b0000 gives divide-by-2. A one-shot expiry arrives start value times divisor cycles after the start-value write.
- R3: The current count starts at the written start value and falls by one every divisor bus cycles.
- R4: A start-value write abandons any countdown in progress and restarts the count from the new value with a fresh divisor phase.
- R5: Writing a start value of zero leaves the timer stopped. The current count then reads zero and no interrupt follows.
- R6: In one-shot mode (timer entry bit 17 clear) expiry produces exactly one pulse. The current count then stays at zero until the next start-value write.
- R7: In periodic mode (timer entry bit 17 set) the count reloads the start value at expiry and pulses repeat every start value times divisor cycles.
- R8: At expiry `irq_pulse` is high for one cycle, with `irq_vector` equal to timer entry bits 7:0, but only if timer entry bit 16 (mask) is clear.
- R9: A write to the timer entry keeps only bits 7:0, 12, 16 and 17. A write to entries 1 to 5 keeps only bits 7:0, 10:8, 12 and 16.
- R10: While the unit-control enable bit (bit 8) is clear, any write to a local entry stores it with bit 16 forced on. The unit-control register keeps bits 9:0.
- R11: A unit-control write with bit 8 clear sets bit 16 in all six entries. An expiry in the same cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes (0-5 entries, 6 control, 7 start value, 9 divide) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for reads (8 adds the current count) |
| rd_data | output | 32 | Combinational read data |
| irq_pulse | output | 1 | One-cycle interrupt request at expiry |
| irq_vector | output | 8 | Vector presented with the request |

## Verification
A write is sampled at one clock edge, and its register effect is readable combinationally right after that edge. The current count after edge k from a start-value write equals the start value minus floor(k / divisor). The interrupt pulse is registered, so it is visible just after edge start times divisor, counted from the write edge. The bench drives and samples only on falling edges and counts those edges from the write, so every expected value is checked in exactly the cycle it becomes due. The disable-versus-expiry race is staged by placing the control write on the expiry edge itself.

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
  parameter int CNT_W   = 32,
  parameter int NUM_LVT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        irq_pulse,
  output logic [7:0]  irq_vector
);

  localparam logic [3:0]  SEL_CTRL  = 4'd6;
  localparam logic [3:0]  SEL_START = 4'd7;
  localparam logic [3:0]  SEL_CUR   = 4'd8;
  localparam logic [3:0]  SEL_DIV   = 4'd9;
  localparam int          MASK_BIT  = 16;
  localparam int          PER_BIT   = 17;
  localparam int          EN_BIT    = 8;
  localparam logic [31:0] MASK_ONE  = 32'h0001_0000;
  localparam logic [31:0] TMR_KEEP  = 32'h0003_10FF;
  localparam logic [31:0] LVT_KEEP  = 32'h0001_17FF;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [NUM_LVT-1:0][31:0] lvt;
  logic [NUM_LVT-1:0]       mask_vec;
  logic [9:0]               ctrl;
  logic [3:0]               div_cfg;
  logic [CNT_W-1:0]         start_cnt, cur_cnt;
  logic                     running;
  logic [6:0]               presc;

  wire             sw_en     = ctrl[EN_BIT];
  wire [2:0]       div_log   = {div_cfg[3], div_cfg[1:0]} + 3'd1;
  wire [7:0]       div_last  = (8'd1 << div_log) - 8'd1;
  wire             start_wr  = wr_en && (wr_sel == SEL_START);
  wire             disabling = wr_en && (wr_sel == SEL_CTRL) && !wr_data[EN_BIT];
  wire             tick      = running && ({1'b0, presc} >= div_last);
  wire             expire    = tick && (cur_cnt == ONE) && !start_wr;
  wire [CNT_W-1:0] new_start = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LVT; i++) lvt[i] <= MASK_ONE;
    end else begin
      for (int i = 0; i < NUM_LVT; i++) begin
        if (disabling)
          lvt[i][MASK_BIT] <= 1'b1;
        else if (wr_en && wr_sel == 4'(i))
          lvt[i] <= (wr_data | (sw_en ? 32'h0 : MASK_ONE)) & ((i == 0) ? TMR_KEEP : LVT_KEEP);
      end
    end
  end

  always_comb
    for (int i = 0; i < NUM_LVT; i++) mask_vec[i] = lvt[i][MASK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= 10'h0FF;
      div_cfg <= 4'h0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) ctrl    <= wr_data[9:0];
      if (wr_sel == SEL_DIV)  div_cfg <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_cnt <= '0;
      cur_cnt   <= '0;
      running   <= 1'b0;
      presc     <= '0;
    end else if (start_wr) begin
      start_cnt <= new_start;
      cur_cnt   <= new_start;
      running   <= (new_start != '0);
      presc     <= '0;
    end else if (tick) begin
      presc <= '0;
      if (cur_cnt == ONE) begin
        if (lvt[0][PER_BIT]) cur_cnt <= start_cnt;
        else begin
          cur_cnt <= '0;
          running <= 1'b0;
        end
      end else begin
        cur_cnt <= cur_cnt - ONE;
      end
    end else if (running) begin
      presc <= presc + 7'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= 8'h00;
    end else begin
      irq_pulse <= expire && !lvt[0][MASK_BIT] && !disabling;
      if (expire) irq_vector <= lvt[0][7:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_LVT; i++)
      if (rd_sel == 4'(i)) rd_data = lvt[i];
    case (rd_sel)
      SEL_CTRL:  rd_data = 32'(ctrl);
      SEL_START: rd_data = 32'(start_cnt);
      SEL_CUR:   rd_data = 32'(cur_cnt);
      SEL_DIV:   rd_data = 32'(div_cfg);
      default:   ;
    endcase
  end

endmodule

// File: rtl/local_irq_timer_chk.sv
module local_irq_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_LVT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [3:0]         wr_sel,
  input logic [31:0]        wr_data,
  input logic               irq_pulse,
  input logic [CNT_W-1:0]   cur_cnt,
  input logic [NUM_LVT-1:0] mask_vec
);

  wire start_wr = wr_en && (wr_sel == 4'd7);

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && wr_data[CNT_W-1:0] != '0) |=> cur_cnt == $past(wr_data[CNT_W-1:0]));

  // R5
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && wr_data[CNT_W-1:0] == '0) |=> cur_cnt == '0);

  // R6
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cnt == '0 && !start_wr) |=> cur_cnt == '0);

  // R8
  pulse_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(mask_vec[0]));

  // R8
  pulse_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(cur_cnt) == CNT_W'(1));

  // R11
  disable_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'd6 && !wr_data[8]) |=> (&mask_vec) && !irq_pulse);

endmodule

bind local_irq_timer local_irq_timer_chk #(.CNT_W(CNT_W), .NUM_LVT(NUM_LVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .irq_pulse(irq_pulse), .cur_cnt(cur_cnt), .mask_vec(mask_vec));

// File: tb/local_irq_timer_bench.sv
module local_irq_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  local_irq_timer u_local_irq_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] val);
    rd_sel = sel; #1; val = rd_data;
  endtask

  task automatic wait_pulse(input int maxk, output int k, output logic [7:0] vec);
    k = 0; vec = 8'h00;
    for (int i = 1; i <= maxk; i++) begin
      @(negedge clk);
      if (irq_pulse) begin k = i; vec = irq_vector; break; end
    end
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pulse) seen++;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R0: watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] vec;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin rd(4'(i), v); chk("R1 entry reset", v, 32'h0001_0000); end
    rd(4'd9, v); chk("R1 divide reset", v, 0);
    rd(4'd7, v); chk("R1 start reset", v, 0);
    rd(4'd8, v); chk("R1 count reset", v, 0);
    rd(4'd6, v); chk("R1 control reset", v, 32'h0FF);

    // R10: forced mask while disabled
    wr(4'd0, 32'h0000_0020); rd(4'd0, v); chk("R10 forced mask", v, 32'h0001_0020);
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, v); chk("R10 control keep", v, 32'h3FF);

    // R9: write filtering
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R9 timer keep", v, 32'h0003_10FF);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, v); chk("R9 entry keep", v, 32'h0001_17FF);

    // R2 sweep of all divide settings, one-shot
    wr(4'd0, 32'h0000_0042);
    for (int c = 0; c < 16; c++) begin
      int n, d;
      logic [3:0] cb;
      cb = 4'(c);
      n = ({cb[3], cb[1], cb[0]} + 1) % 8;
      d = 1 << n;
      wr(4'd9, 32'(c));
      wr(4'd7, 32'd3);
      wait_pulse(3 * d + 10, k, vec);
      chk("R2 expiry cycle", k, 3 * d);
      chk("R8 vector", vec, 8'h42);
      @(negedge clk);
      chk("R8 single cycle", irq_pulse, 0);
      rd(4'd8, v); chk("R6 held zero", v, 0);
    end
    quiet("R6 no second pulse", 20);
    rd(4'd8, v); chk("R6 still zero", v, 0);

    // R3: count readback with divide-by-2
    wr(4'd9, 32'h0);
    wr(4'd7, 32'd5);
    rd_sel = 4'd8;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk); #1;
      chk("R3 count step", rd_data, 32'(5 - i / 2));
    end
    @(negedge clk);
    chk("R3 expiry after last step", irq_pulse, 1);

    // R7: periodic, divide-by-1
    wr(4'd0, 32'h0002_0055);
    wr(4'd9, 32'hB);
    wr(4'd7, 32'd4);
    for (int p = 0; p < 3; p++) begin
      wait_pulse(20, k, vec);
      chk("R7 period", k, 4);
      chk("R7 vector", vec, 8'h55);
      rd(4'd8, v); chk("R7 reload", v, 4);
    end

    // R5: zero start stops the timer
    wr(4'd7, 32'd0);
    rd(4'd8, v); chk("R5 count zero", v, 0);
    quiet("R5 no pulse", 20);

    // R4: restart on start-value write
    wr(4'd0, 32'h0000_0042);
    wr(4'd7, 32'd10);
    repeat (6) @(negedge clk);
    wr(4'd7, 32'd4);
    rd(4'd8, v); chk("R4 reload value", v, 4);
    wait_pulse(20, k, vec);
    chk("R4 restart timing", k, 4);

    // R8: masked expiry gives no pulse
    wr(4'd0, 32'h0001_0042);
    wr(4'd7, 32'd3);
    quiet("R8 masked", 10);
    rd(4'd8, v); chk("R8 masked count ran out", v, 0);

    // R11: disable on the expiry edge
    for (int i = 0; i < 6; i++) wr(4'(i), 32'(8'h30 + i));
    rd(4'd2, v); chk("R11 unmasked before", v, 32'h32);
    wr(4'd7, 32'd2);
    @(negedge clk);
    wr(4'd6, 32'h0FF);
    chk("R11 pulse dropped", irq_pulse, 0);
    for (int i = 0; i < 6; i++) begin
      rd(4'(i), v); chk("R11 mask set", v[16], 1);
    end
    quiet("R11 no later pulse", 10);
    wr(4'd2, 32'h7); rd(4'd2, v); chk("R10 forced mask again", v, 32'h0001_0007);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule